// File: doc/BRIEF.md
# Two-Bank Latched Interrupt Controller

This block collects 64 interrupt request lines into two banks of 32 and presents them to a processor through a small word-addressed register window and a single interrupt output. Each raw line is first brought into the clock domain by a two-flop synchronizer. A bank latches a request into its flag register only when its synchronized input makes a low-to-high transition while the matching enable bit is set. Software clears latched requests by writing ones to the acknowledge register.

The interrupt output is high whenever any flag in either bank is set, one register stage after the flags. A read-only vector word names the pending source to service. It searches the upper bank (sources 32 to 63) first and the lower bank (sources 0 to 31) second, and within a bank it takes the highest set bit. The raw, synchronized input state can be read at any time through each bank's level register. Because flags are edge-triggered, enabling a line that is already high does not raise an interrupt. Software must re-check the level register when it unmasks a line.

Top module: `irqc_top`

## Requirements
- R1: After reset, every flag and enable bit is 0, `irq_out` is low, and the vector word reads 0x8000_0000.
- R2: A flag bit sets on the third rising clock edge after its raw input goes high, but only if the matching enable bit is 1. The flag then stays set.
- R3: A write to a bank's acknowledge register clears the flag bits where the written data is 1 and leaves the other flag bits unchanged. Writing all zeros changes nothing.
- R4: The level register returns the synchronized raw inputs of its bank whatever the enable bits hold. An input change is visible there two clock edges after it happens.
- R5: Setting an enable bit while that source's input is already high does not set its flag and does not raise `irq_out`. A later new rising edge on that input does set the flag.
- R6: With both enable registers at zero, no input activity sets any flag or raises `irq_out`.
- R7: Clearing an enable bit leaves an already-set flag bit, and `irq_out`, in place until that flag is acknowledged.
- R8: `irq_out` equals the OR of all 64 flags as they stood one clock edge earlier.
- R9: The vector word returns the source number in bits 5:0. The number is 32 plus the highest set flag of the upper bank if that bank has any flag set, and otherwise the highest set flag of the lower bank. When no flag is set, bit 31 is 1 and bits 5:0 are 0.
- R10: The window uses word addresses (byte offset = 4 x word). Word 0x0 is the vector word. The upper bank sits at words 0x4 to 0x7 and the lower bank at words 0x8 to 0xB, and within a bank the words are flag, enable, acknowledge, level. A write to one bank's enable does not touch the other bank's enable.
- R11: If a flag's set condition and an acknowledge of that bit fall on the same clock edge, the flag ends set.
- R12: Read data appears on `bus_rdata` after the clock edge that sampled `bus_re`. The acknowledge words, vector-region words 0x1 to 0x3 and words 0xC to 0xF read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src | input | 64 | Raw interrupt request lines, bit n is source n |
| bus_addr | input | 4 | Word address within the register window |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, acted on at the clock edge |
| bus_re | input | 1 | Read strobe, data returned after the clock edge |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Processor interrupt, high while any flag is set |

## Verification
A raw input change needs two edges to reach the level register, a third edge to reach the flag, and a fourth to reach `irq_out`. The bench changes inputs just after a falling edge and counts rising edges to these points. It samples `irq_out` at the falling edges after the third and after the fourth rising edge, so the edge on which the interrupt appears is pinned down. After an acknowledge, `irq_out` is checked to remain high for one more edge and then to fall. All register reads are sampled at the falling edge after the rising edge that took `bus_re`. The same-edge set/acknowledge case is timed so that the write lands on the exact edge on which the flag sets.

// File: rtl/irqc_pkg.sv
// Package: shared decode constants for the two-bank interrupt controller.
// Assumes a word-addressed 16-word window: address bits [3:2] pick a
// region and bits [1:0] pick the word within a bank.
package irqc_pkg;

    // Word selector inside a bank; this order is the decoded layout.
    typedef enum logic [1:0] {
        SEL_FLAG  = 2'd0,
        SEL_EN    = 2'd1,
        SEL_ACK   = 2'd2,
        SEL_LEVEL = 2'd3
    } reg_sel_e;

    // Region codes taken from word address bits [3:2].
    localparam logic [1:0] RGN_VEC = 2'd0;
    localparam logic [1:0] RGN_HI  = 2'd1;
    localparam logic [1:0] RGN_LO  = 2'd2;

endpackage

// File: rtl/irqc_sync.sv
// Module: irqc_sync
// Multi-stage synchronizer that brings asynchronous request lines into the
// clock domain. Assumes each line is held long enough to be sampled.
module irqc_sync #(
    parameter int W      = 64,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    // Shift the inputs through the flop chain, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/irqc_bank.sv
// Module: irqc_bank
// One bank of latched interrupt sources: an enable register, an
// edge detector on the synchronized inputs, and sticky flags cleared by
// write-one acknowledge. Assumes src is already synchronous to clk.
module irqc_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic         en_we,
    input  logic         ack_we,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] flag,
    output logic [W-1:0] en,
    output logic [W-1:0] set_pulse
);

    logic [W-1:0] src_prev;
    logic [W-1:0] ack_mask;

    // Rising edge on an enabled source requests a flag.
    assign set_pulse = src & ~src_prev & en;
    assign ack_mask  = ack_we ? wr_data : '0;

    // Remember the previous input sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_prev <= '0;
        else        src_prev <= src;
    end

    // Enable register, written whole by software.
    always_ff @(posedge clk) begin
        if (!rst_n)     en <= '0;
        else if (en_we) en <= wr_data;
    end

    // Sticky flags: acknowledge clears, a new request sets and wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= '0;
        else        flag <= (flag & ~ack_mask) | set_pulse;
    end

endmodule

// File: rtl/irqc_prio.sv
// Module: irqc_prio
// Pending-source encoder: the upper bank takes precedence over the lower
// one, and within a bank the highest set bit wins. Bit 31 marks "none".
// Assumes IDW + 1 <= 32.
module irqc_prio #(
    parameter int BANK_W = 32,
    parameter int IDW    = 6
) (
    input  logic [BANK_W-1:0] lo,
    input  logic [BANK_W-1:0] hi,
    output logic [31:0]       vec
);

    logic [IDW-1:0] id;
    logic           none;

    // Ascending scans so the last hit is the highest bit; upper bank overrides.
    always_comb begin
        id   = '0;
        none = (lo == '0) && (hi == '0);
        for (int i = 0; i < BANK_W; i++)
            if (lo[i]) id = IDW'(i);
        if (hi != '0) begin
            for (int i = 0; i < BANK_W; i++)
                if (hi[i]) id = IDW'(BANK_W + i);
        end
        vec = {none, {(31-IDW){1'b0}}, id};
    end

endmodule

// File: rtl/irqc_top.sv
// Module: irqc_top
// Two-bank latched interrupt controller with a word-addressed register
// window, registered read data and a registered interrupt output.
// Assumes BANK_W is 32 so each bank fills a full data word.
module irqc_top #(
    parameter int BANK_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*BANK_W-1:0] irq_src,
    input  logic [3:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    input  logic                bus_we,
    input  logic                bus_re,
    output logic [31:0]         bus_rdata,
    output logic                irq_out
);
    import irqc_pkg::*;

    localparam int NUM_SRC = 2 * BANK_W;
    localparam int IDW     = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] src_sync;
    logic [NUM_SRC-1:0] flag_all;
    logic [NUM_SRC-1:0] en_all;
    logic [NUM_SRC-1:0] set_all;
    logic [31:0]        vec_word;
    logic [31:0]        rd_next;
    logic [1:0]         rgn;
    reg_sel_e           sel;

    assign rgn = bus_addr[3:2];
    assign sel = reg_sel_e'(bus_addr[1:0]);

    irqc_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (irq_src),
        .q     (src_sync)
    );

    // Bank 0 serves sources 0..BANK_W-1, bank 1 the rest.
    for (genvar b = 0; b < 2; b++) begin : g_bank
        localparam logic [1:0] MY_RGN = (b == 0) ? RGN_LO : RGN_HI;
        logic hit;
        assign hit = (rgn == MY_RGN);

        irqc_bank #(.W(BANK_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .src       (src_sync[b*BANK_W +: BANK_W]),
            .en_we     (bus_we && hit && sel == SEL_EN),
            .ack_we    (bus_we && hit && sel == SEL_ACK),
            .wr_data   (bus_wdata[BANK_W-1:0]),
            .flag      (flag_all[b*BANK_W +: BANK_W]),
            .en        (en_all[b*BANK_W +: BANK_W]),
            .set_pulse (set_all[b*BANK_W +: BANK_W])
        );
    end

    irqc_prio #(.BANK_W(BANK_W), .IDW(IDW)) u_prio (
        .lo  (flag_all[BANK_W-1:0]),
        .hi  (flag_all[NUM_SRC-1:BANK_W]),
        .vec (vec_word)
    );

    // Select the read word for the addressed region and selector.
    always_comb begin
        rd_next = '0;
        case (rgn)
            RGN_VEC: if (sel == SEL_FLAG) rd_next = vec_word;
            RGN_HI, RGN_LO: begin
                case (sel)
                    SEL_FLAG:  rd_next = (rgn == RGN_HI) ? flag_all[NUM_SRC-1:BANK_W]
                                                         : flag_all[BANK_W-1:0];
                    SEL_EN:    rd_next = (rgn == RGN_HI) ? en_all[NUM_SRC-1:BANK_W]
                                                         : en_all[BANK_W-1:0];
                    SEL_LEVEL: rd_next = (rgn == RGN_HI) ? src_sync[NUM_SRC-1:BANK_W]
                                                         : src_sync[BANK_W-1:0];
                    default:   rd_next = '0;
                endcase
            end
            default: rd_next = '0;
        endcase
    end

    // Register read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_next;
    end

    // Interrupt output follows the OR of all flags one edge later.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= |flag_all;
    end

endmodule

// File: rtl/irqc_checker.sv
// Module: irqc_checker
// Temporal checks on flag, enable and interrupt behaviour, bound into
// irqc_top. Assumes the top's internal vectors flag_all, en_all, set_all.
module irqc_checker #(
    parameter int BANK_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_we,
    input logic [3:0]          bus_addr,
    input logic [31:0]         bus_wdata,
    input logic                irq_out,
    input logic [2*BANK_W-1:0] flag_all,
    input logic [2*BANK_W-1:0] en_all,
    input logic [2*BANK_W-1:0] set_all
);

    logic is_ack;
    logic is_lo_ack;

    // Decode acknowledge writes independently of the design.
    assign is_ack    = bus_we && bus_addr[1:0] == 2'd2 &&
                       (bus_addr[3:2] == 2'd1 || bus_addr[3:2] == 2'd2);
    assign is_lo_ack = bus_we && bus_addr == 4'hA;

    // R1: reset clears flags, enables and the output.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (flag_all == '0 && en_all == '0 && !irq_out));

    // R6: a flag can only newly appear where the enable was set.
    a_r6_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_all & ~$past(flag_all) & ~$past(en_all)) == '0);

    // R7: a flag falls only through an acknowledge write.
    a_r7_fall_only_by_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flag_all) & ~flag_all) != '0) |-> $past(is_ack));

    // R8: output rises after any flag, falls after none.
    a_r8_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_all != '0) |=> irq_out);
    a_r8_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_all == '0) |=> !irq_out);

    // R3: an acknowledge with no competing request clears the written bits.
    a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (is_lo_ack && set_all[BANK_W-1:0] == '0) |=>
        (flag_all[BANK_W-1:0] & $past(bus_wdata[BANK_W-1:0])) == '0);

    // R11: every requested set is present after the edge, ack or not.
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_all != '0) |=> ((flag_all & $past(set_all)) == $past(set_all)));

endmodule

bind irqc_top irqc_checker #(.BANK_W(BANK_W)) u_irqc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_out   (irq_out),
    .flag_all  (flag_all),
    .en_all    (en_all),
    .set_all   (set_all)
);

// File: tb/irqc_top_bench.sv
// Bench: directed scenarios for irqc_top, one task each, self-checking.
module irqc_top_bench;

    localparam logic [3:0] A_VEC  = 4'h0;
    localparam logic [3:0] A_HFLG = 4'h4, A_HEN = 4'h5, A_HACK = 4'h6, A_HLVL = 4'h7;
    localparam logic [3:0] A_LFLG = 4'h8, A_LEN = 4'h9, A_LACK = 4'hA, A_LLVL = 4'hB;
    localparam logic [31:0] NONE = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic [31:0] rdata;
    logic        irq;
    int          checks = 0;
    int          fails = 0;
    logic [31:0] rv;

    always #5 clk = ~clk;

    irqc_top u_irqc_top (
        .clk (clk), .rst_n (rst_n), .irq_src (src), .bus_addr (addr),
        .bus_wdata (wdata), .bus_we (we), .bus_re (re),
        .bus_rdata (rdata), .irq_out (irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(posedge clk); #1 we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; re = 1'b1;
        @(posedge clk);
        @(negedge clk); d = rdata; re = 1'b0;
    endtask

    // Drive the inputs and wait until flags and the output have settled.
    task automatic drive(input logic [63:0] v);
        @(negedge clk); src = v;
        repeat (4) @(posedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk); check("R1", "irq after reset", {31'b0, irq}, 32'h0);
        rd(A_VEC, rv);  check("R1", "vector after reset", rv, NONE);
        rd(A_LEN, rv);  check("R1", "lo enable", rv, 32'h0);
        rd(A_HFLG, rv); check("R1", "hi flag", rv, 32'h0);
    endtask

    task automatic t_latch_timing;
        wr(A_LEN, 32'h20);
        @(negedge clk); src[5] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); check("R8", "irq before 4th edge", {31'b0, irq}, 32'h0);
        @(negedge clk); check("R8", "irq at 4th edge", {31'b0, irq}, 32'h1);
        rd(A_LFLG, rv); check("R2", "lo flag bit5", rv, 32'h20);
        wr(A_LACK, 32'h20);
        @(negedge clk); check("R8", "irq one edge after ack", {31'b0, irq}, 32'h1);
        @(negedge clk); check("R8", "irq two edges after ack", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_ack_partial;
        wr(A_LEN, 32'hFFFF_FFFF);
        drive(64'h0);
        drive(64'h7);
        rd(A_LFLG, rv); check("R2", "three flags", rv, 32'h7);
        wr(A_LACK, 32'h5);
        rd(A_LFLG, rv); check("R3", "partial ack", rv, 32'h2);
        wr(A_LACK, 32'h0);
        rd(A_LFLG, rv); check("R3", "zero ack no change", rv, 32'h2);
        wr(A_LACK, 32'h2);
        rd(A_LFLG, rv); check("R3", "final ack", rv, 32'h0);
    endtask

    task automatic t_level;
        drive(64'h0);
        @(negedge clk); src[40] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk); addr = A_HLVL; re = 1'b1;
        @(posedge clk); @(negedge clk); re = 1'b0;
        check("R4", "hi level bit8", rdata, 32'h100);
        rd(A_HFLG, rv); check("R6", "disabled hi no flag", rv, 32'h0);
        check("R6", "irq stays low", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_enable_while_high;
        wr(A_HEN, 32'h100);
        repeat (4) @(posedge clk);
        rd(A_HFLG, rv); check("R5", "enable on high input", rv, 32'h0);
        check("R5", "irq after enable on high", {31'b0, irq}, 32'h0);
        drive(64'h0);
        drive(64'h1 << 40);
        rd(A_HFLG, rv); check("R5", "new edge after enable", rv, 32'h100);
    endtask

    task automatic t_disable_keeps;
        wr(A_HEN, 32'h0);
        rd(A_HFLG, rv); check("R7", "flag kept after disable", rv, 32'h100);
        check("R7", "irq kept after disable", {31'b0, irq}, 32'h1);
        wr(A_HACK, 32'h100);
        rd(A_HFLG, rv); check("R7", "ack after disable", rv, 32'h0);
    endtask

    task automatic t_all_disabled;
        wr(A_LEN, 32'hFFFF_FFFF); wr(A_HEN, 32'hFFFF_FFFF);
        wr(A_LEN, 32'h0);         wr(A_HEN, 32'h0);
        drive(64'h0);
        drive('1);
        rd(A_LFLG, rv); check("R6", "lo flags with no enable", rv, 32'h0);
        rd(A_HFLG, rv); check("R6", "hi flags with no enable", rv, 32'h0);
        check("R6", "irq with no enable", {31'b0, irq}, 32'h0);
        drive(64'h0);
    endtask

    task automatic t_priority;
        wr(A_LEN, 32'hFFFF_FFFF); wr(A_HEN, 32'hFFFF_FFFF);
        drive((64'h1 << 3) | (64'h1 << 20));
        rd(A_VEC, rv); check("R9", "lo highest", rv, 32'd20);
        drive((64'h1 << 3) | (64'h1 << 20) | (64'h1 << 33));
        rd(A_VEC, rv); check("R9", "hi bank first", rv, 32'd33);
        drive((64'h1 << 3) | (64'h1 << 20) | (64'h1 << 33) | (64'h1 << 63));
        rd(A_VEC, rv); check("R9", "hi highest", rv, 32'd63);
        wr(A_HACK, 32'hFFFF_FFFF);
        rd(A_VEC, rv); check("R9", "back to lo", rv, 32'd20);
        wr(A_LACK, 32'h0010_0000);
        rd(A_VEC, rv); check("R9", "next lo", rv, 32'd3);
        wr(A_LACK, 32'hFFFF_FFFF);
        rd(A_VEC, rv); check("R9", "empty", rv, NONE);
    endtask

    task automatic t_set_vs_ack;
        @(negedge clk); src[7] = 1'b1;
        repeat (2) @(posedge clk);
        wr(A_LACK, 32'h80);
        rd(A_LFLG, rv); check("R11", "set beats ack", rv, 32'h80);
        wr(A_LACK, 32'h80);
        rd(A_LFLG, rv); check("R11", "later ack clears", rv, 32'h0);
    endtask

    task automatic t_map;
        wr(A_LEN, 32'hAAAA_5555); wr(A_HEN, 32'h0);
        rd(A_LEN, rv); check("R10", "lo enable readback", rv, 32'hAAAA_5555);
        rd(A_HEN, rv); check("R10", "hi enable untouched", rv, 32'h0);
        wr(A_HEN, 32'h1234_5678);
        rd(A_LEN, rv); check("R10", "lo enable untouched", rv, 32'hAAAA_5555);
        rd(4'hC, rv);   check("R12", "unmapped word", rv, 32'h0);
        rd(A_LACK, rv); check("R12", "ack reads zero", rv, 32'h0);
        rd(4'h1, rv);   check("R12", "vector region word1", rv, 32'h0);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_latch_timing();
        t_ack_partial();
        t_level();
        t_enable_while_high();
        t_disable_keeps();
        t_all_disabled();
        t_priority();
        t_set_vs_ack();
        t_map();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R1..: actual timeout expected completion");
        finish_run();
    end

endmodule